// File: doc/BRIEF.md
# Chained-Entry Key Lookup Engine

This block searches a linked chain of fixed-size entries held in external memory for one that carries a given key. A command gives a starting entry address, a word address in a local result memory, a 32-bit search key and a cap on how many entries may be examined. For each entry the engine issues one read request and takes back eight 32-bit words. It first tests the entry's invalid marker and then compares the key field. If neither ends the search, it follows the entry's next pointer.

The search has three outcomes. A key match copies the whole matched entry into the local result memory and reports a hit. An entry carrying the invalid marker reports a miss. Examining the permitted number of entries without either event reports that the limit was exhausted. Completion is a single-cycle pulse with a two-bit status code. The result memory has a registered read port, so software-facing logic can read matched entries back.

Top module: `chain_lookup`

## Requirements
- R1: A command (`cmd_valid` high at a clock edge) is accepted only while the engine is idle. `busy` is high from the cycle after acceptance until the cycle in which `done` rises, when it falls. A command presented while `busy` is high is ignored.
- R2: Each entry fetch is a single-cycle `mem_req` pulse carrying the entry's byte address with its low five bits forced to zero. The eight words follow on `mem_rdata`, qualified by `mem_rvalid`, in word order 0..7, with any number of idle cycles between them. `mem_rvalid` has no effect while the engine is not waiting for words.
- R3: The entry layout is as follows. Word 0 bit 31 is the invalid marker. Word 0 bits [29:0] are the next entry's byte address, with bits [4:0] ignored. Word 0 bit 30 is ignored. Word 1 is the compare key. The command's start address also has its low five bits ignored.
- R4: When an entry is valid and its word 1 equals the key, status becomes 2'b01. Words 0..7 of that entry, unchanged, are written to result memory addresses dest, dest+1, ..., dest+7, modulo the memory depth.
- R5: An entry with the invalid marker set ends the search with status 2'b10, even when its word 1 equals the key. The invalid test comes before the key compare.
- R6: When `limit` entries have been examined without a match or an invalid entry, status becomes 2'b11 and no further fetch is made. A limit of 0 reports 2'b11 in the cycle after acceptance, with no fetch and without raising `busy`.
- R7: `done` is high for exactly one cycle per accepted command. `status` changes only when `done` is high and holds its value between completions. After reset, `busy`, `done`, `mem_req` and `status` are all zero.
- R8: Result memory reads return the word at `res_raddr` one cycle later. The result memory is written only when a lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_start | input | ADDR_W | Byte address of the first entry |
| cmd_dest | input | RES_AW | Result memory word address for a matched entry |
| cmd_key | input | 32 | Search key |
| cmd_limit | input | LIMIT_W | Maximum number of entries to examine |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 01 hit, 10 invalid entry reached, 11 limit exhausted |
| mem_req | output | 1 | Entry fetch request pulse |
| mem_addr | output | ADDR_W | 32-byte aligned entry byte address |
| mem_rvalid | input | 1 | Returned word valid |
| mem_rdata | input | 32 | Returned word |
| res_raddr | input | RES_AW | Result memory read address |
| res_rdata | output | 32 | Result memory read data, one cycle after address |

## Verification
Several properties are checked on every cycle. The request pulse lasts one cycle, is issued only while busy and always carries an aligned address. Busy ends only with a completion pulse, the completion pulse lasts one cycle and the status holds between completions. Other behaviour only the bench scenarios can show. These are which outcome a given chain, key and limit produce, how many entries are fetched before the search ends, and the exact words copied into the result memory. They also include the precedence of the invalid marker over a matching key, the ignored pointer bits, result memory wrap-around, and the rejection of commands and stray read data while the engine is busy or idle.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int ENTRY_WORDS = 8;

  typedef enum logic [1:0] {
    LK_NONE  = 2'b00,
    LK_HIT   = 2'b01,
    LK_MISS  = 2'b10,
    LK_LIMIT = 2'b11
  } lk_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_EVAL,
    S_COPY
  } lk_state_e;
endpackage

// File: rtl/lk_entry_buf.sv
module lk_entry_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 8,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic              last_beat
);
  logic [DATA_W-1:0] words [BEATS];
  logic [IDX_W-1:0]  cnt;

  // beat counter restarts whenever capture is not enabled
  always_ff @(posedge clk) begin
    if (rst || !cap_en) cnt <= '0;
    else if (beat_valid) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cap_en && beat_valid) words[cnt] <= beat_data;
  end

  assign last_beat = cap_en && beat_valid && (cnt == IDX_W'(BEATS - 1));
  assign rd_word   = words[rd_idx];
  assign word0     = words[0];
  assign word1     = words[1];
endmodule

// File: rtl/lk_result_ram.sv
module lk_result_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lk_ctrl.sv
module lk_ctrl
  import lk_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int RES_AW  = 5,
  parameter int LIMIT_W = 8,
  parameter int BEATS   = ENTRY_WORDS,
  localparam int IDX_W  = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [ADDR_W-1:0]  cmd_start,
  input  logic [RES_AW-1:0]  cmd_dest,
  input  logic [31:0]        cmd_key,
  input  logic [LIMIT_W-1:0] cmd_limit,
  input  logic [31:0]        word0,
  input  logic [31:0]        word1,
  input  logic               last_beat,
  input  logic [31:0]        rd_word,
  output logic               cap_en,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               ram_we,
  output logic [RES_AW-1:0]  ram_waddr,
  output logic [31:0]        ram_wdata,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr
);
  localparam int INV_BIT = 31;

  lk_state_e          state;
  logic [31:0]        key_q;
  logic [RES_AW-1:0]  dest_q;
  logic [LIMIT_W-1:0] remain;
  logic [IDX_W-1:0]   cidx;

  function automatic logic [ADDR_W-1:0] align32(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:5], 5'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      status   <= LK_NONE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      key_q    <= '0;
      dest_q   <= '0;
      remain   <= '0;
      cidx     <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            key_q  <= cmd_key;
            dest_q <= cmd_dest;
            remain <= cmd_limit;
            if (cmd_limit == '0) begin
              done   <= 1'b1;
              status <= LK_LIMIT;
            end else begin
              busy     <= 1'b1;
              mem_req  <= 1'b1;
              mem_addr <= align32(cmd_start);
              state    <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (last_beat) state <= S_EVAL;
        end
        S_EVAL: begin
          if (word0[INV_BIT]) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            status <= LK_MISS;
            state  <= S_IDLE;
          end else if (word1 == key_q) begin
            cidx  <= '0;
            state <= S_COPY;
          end else if (remain == LIMIT_W'(1)) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            status <= LK_LIMIT;
            state  <= S_IDLE;
          end else begin
            remain   <= remain - 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= align32(word0[ADDR_W-1:0]);
            state    <= S_FETCH;
          end
        end
        S_COPY: begin
          cidx <= cidx + 1'b1;
          if (cidx == IDX_W'(BEATS - 1)) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            status <= LK_HIT;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cap_en    = (state == S_FETCH);
  assign rd_idx    = cidx;
  assign ram_we    = (state == S_COPY);
  assign ram_waddr = dest_q + RES_AW'(cidx);
  assign ram_wdata = rd_word;
endmodule

// File: rtl/chain_lookup.sv
module chain_lookup
  import lk_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int RES_AW  = 5,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [ADDR_W-1:0]  cmd_start,
  input  logic [RES_AW-1:0]  cmd_dest,
  input  logic [31:0]        cmd_key,
  input  logic [LIMIT_W-1:0] cmd_limit,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic [RES_AW-1:0]  res_raddr,
  output logic [31:0]        res_rdata
);
  localparam int BEATS = ENTRY_WORDS;
  localparam int IDX_W = $clog2(BEATS);

  logic              cap_en;
  logic              last_beat;
  logic [IDX_W-1:0]  rd_idx;
  logic [31:0]       rd_word;
  logic [31:0]       word0;
  logic [31:0]       word1;
  logic              ram_we;
  logic [RES_AW-1:0] ram_waddr;
  logic [31:0]       ram_wdata;

  lk_entry_buf #(.DATA_W(32), .BEATS(BEATS)) u_buf (
    .clk(clk), .rst(rst), .cap_en(cap_en), .beat_valid(mem_rvalid),
    .beat_data(mem_rdata), .rd_idx(rd_idx), .rd_word(rd_word),
    .word0(word0), .word1(word1), .last_beat(last_beat)
  );

  lk_ctrl #(.ADDR_W(ADDR_W), .RES_AW(RES_AW), .LIMIT_W(LIMIT_W), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_dest(cmd_dest), .cmd_key(cmd_key), .cmd_limit(cmd_limit),
    .word0(word0), .word1(word1), .last_beat(last_beat), .rd_word(rd_word),
    .cap_en(cap_en), .rd_idx(rd_idx), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .busy(busy), .done(done), .status(status),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  lk_result_ram #(.DATA_W(32), .AW(RES_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(res_raddr), .rdata(res_rdata)
  );
endmodule

// File: rtl/chain_lookup_chk.sv
module chain_lookup_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R1
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R2
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R2
  req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[4:0] == 5'd0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(status));

  // R7
  done_status_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'b00));
endmodule

bind chain_lookup chain_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status),
  .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/chain_lookup_bench.sv
`timescale 1ns/1ps
module chain_lookup_bench;
  localparam int ADDR_W  = 30;
  localparam int RES_AW  = 5;
  localparam int LIMIT_W = 8;
  localparam int RDEPTH  = 1 << RES_AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1;
  logic               cmd_valid = 1'b0;
  logic [ADDR_W-1:0]  cmd_start = '0;
  logic [RES_AW-1:0]  cmd_dest = '0;
  logic [31:0]        cmd_key = '0;
  logic [LIMIT_W-1:0] cmd_limit = '0;
  logic               busy, done, mem_req;
  logic [1:0]         status;
  logic [ADDR_W-1:0]  mem_addr;
  logic               mem_rvalid = 1'b0;
  logic [31:0]        mem_rdata = '0;
  logic [RES_AW-1:0]  res_raddr = '0;
  logic [31:0]        res_rdata;

  chain_lookup #(.ADDR_W(ADDR_W), .RES_AW(RES_AW), .LIMIT_W(LIMIT_W)) u_chain_lookup (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_dest(cmd_dest), .cmd_key(cmd_key), .cmd_limit(cmd_limit),
    .busy(busy), .done(done), .status(status), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_raddr(res_raddr), .res_rdata(res_rdata)
  );

  logic [31:0] mem [256];
  logic [31:0] exp_ram [RDEPTH];
  bit          known [RDEPTH];
  int          fetches = 0;
  bit          gap_mode = 1'b0;
  bit          stray = 1'b0;
  bit          bad_addr = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int slot(input int k);
    return (k * 5 + 3) % 32;
  endfunction

  function automatic logic [31:0] key_of(input int k);
    return 32'hC0DE0000 + k * 32'h00010111;
  endfunction

  // memory responder: one request -> eight words, optional gaps
  initial begin
    int base;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (mem_addr[4:0] != 5'd0) bad_addr = 1'b1;
        base = int'(mem_addr >> 2) & 255;
        fetches++;
        for (int b = 0; b < 8; b++) begin
          if (gap_mode && b[0]) begin
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          mem_rvalid = 1'b1;
          mem_rdata  = mem[(base + b) & 255];
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end else if (stray) begin
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = 32'hBAD0_0000 + b;
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
        stray = 1'b0;
      end
    end
  end

  task automatic readback(input string req);
    for (int w = 0; w < RDEPTH; w++) begin
      res_raddr = RES_AW'(w);
      @(negedge clk);
      if (known[w]) chk(res_rdata === exp_ram[w], req, res_rdata, exp_ram[w]);
    end
  endtask

  task automatic run(input int q, input int lim, input int dst, input bit junk);
    logic [1:0] es;
    int ef, hit_k, wait_n;
    hit_k = -1;
    if (lim == 0) begin es = 2'b11; ef = 0; end
    else if (q < 6) begin
      if (q < lim) begin es = 2'b01; ef = q + 1; hit_k = q; end
      else begin es = 2'b11; ef = lim; end
    end else begin
      if (lim >= 7) begin es = 2'b10; ef = 7; end
      else begin es = 2'b11; ef = lim; end
    end
    @(negedge clk);
    fetches   = 0;
    cmd_start = ADDR_W'(slot(0) * 32 + 3);
    cmd_dest  = RES_AW'(dst);
    cmd_key   = (q < 6) ? key_of(q) : (q == 6 ? 32'hDEADBEEF : 32'h12345678);
    cmd_limit = LIMIT_W'(lim);
    cmd_valid = 1'b1;
    @(negedge clk);
    if (lim > 0) begin
      chk(busy === 1'b1, "R1 busy after accept", busy, 1);
      if (junk) begin
        cmd_key   = 32'h0;
        cmd_limit = '0;
        @(negedge clk);
      end
    end
    cmd_valid = 1'b0;
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 3000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done === 1'b1, "R7 done arrives", done, 1);
    chk(status === es, (es == 2'b01) ? "R4 hit status" : (es == 2'b10) ? "R5 invalid status" : "R6 limit status", status, es);
    chk(busy === 1'b0, "R1 busy low at done", busy, 0);
    chk(fetches == ef, "R3 entries fetched", fetches, ef);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
    chk(status === es, "R7 status held", status, es);
    if (hit_k >= 0) begin
      for (int j = 0; j < 8; j++) begin
        exp_ram[(dst + j) % RDEPTH] = mem[slot(hit_k) * 8 + j];
        known[(dst + j) % RDEPTH]   = 1'b1;
      end
    end
    if (junk) begin
      repeat (4) @(negedge clk);
      chk(done === 1'b0, "R1 command while busy ignored", done, 0);
    end
    readback((hit_k >= 0) ? "R4 copied entry" : "R8 memory untouched");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A000000 + i;
    for (int k = 0; k < 7; k++) begin
      int b;
      b = slot(k) * 8;
      if (k == 6) begin
        mem[b]     = 32'h8000_0000 | (slot(0) * 32);
        mem[b + 1] = 32'hDEADBEEF;
      end else begin
        mem[b]     = (slot(k + 1) * 32) | 32'h15 | (k[0] ? 32'h4000_0000 : 32'h0);
        mem[b + 1] = key_of(k);
      end
      for (int j = 2; j < 8; j++) mem[b + j] = k * 256 + j;
    end
    for (int w = 0; w < RDEPTH; w++) known[w] = 1'b0;

    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R7 reset busy", busy, 0);
    chk(done === 1'b0, "R7 reset done", done, 0);
    chk(status === 2'b00, "R7 reset status", status, 0);
    chk(mem_req === 1'b0, "R7 reset mem_req", mem_req, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int q = 0; q < 8; q++) begin
      for (int lim = 0; lim < 9; lim++) begin
        gap_mode = ((q + lim) % 2) == 1;
        run(q, lim, (q * 3 + lim * 5) % RDEPTH, 1'b0);
      end
    end

    // wrap-around destination and command while busy
    gap_mode = 1'b0;
    run(4, 8, RDEPTH - 3, 1'b1);
    run(7, 8, 1, 1'b1);

    // stray read data while idle
    stray = 1'b1;
    repeat (8) @(negedge clk);
    chk(done === 1'b0, "R2 stray data no done", done, 0);
    chk(busy === 1'b0, "R2 stray data no busy", busy, 0);
    readback("R2 stray data no write");

    chk(bad_addr == 1'b0, "R2 aligned requests", bad_addr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule